// File: doc/BRIEF.md
# Transmit Buffer Command Parser

This block sits between a 32-bit transmit data FIFO and a byte-wide MAC transmit stream. The host writes each transmit buffer into the FIFO as two command dwords, A then B, followed by the payload dwords. The block reads those commands and removes the unused bytes in front of the payload and the alignment padding after it. It forwards only the payload bytes, marking the first byte of each packet with a start flag and the last byte with an end flag.

A packet may be spread over several buffers. The segment flags in command A open and close it, and each buffer can carry its own start offset and end alignment. When the final buffer of a packet has been read, the block issues a one-cycle status word. That word carries the host's packet tag and error bits for two cases: a length that disagrees with the buffer sizes, and a packet cut short by a new one.

Top module: `tx_cmd_parser`

## Requirements
- R1: Command A bits 20:16 hold a start offset (0 to 31). That many bytes at the beginning of the buffer's data region are read from the FIFO and never appear on the MAC stream.
- R2: Command A bits 10:0 hold the buffer size. Exactly that many bytes following the offset are forwarded in order. Within a dword, bits 7:0 form the earliest byte and bits 31:24 the latest.
- R3: Command A bits 25:24 select the end alignment: 0 means 4 bytes, 1 means 16, 2 means 32 and 3 means 4. After the data region, whole padding dwords up to that boundary (counted from the buffer's first data dword) are read and discarded. The dword that follows is taken as the next command A.
- R4: Command A bit 13 marks the first segment and bit 12 the last segment. mac_sop is high on the first forwarded byte of a packet. mac_eop is high on the final byte of its last-segment buffer. Neither flag is high unless mac_valid is high, and the byte that follows an end byte is always a start byte.
- R5: A one-cycle stat_valid pulse appears the cycle after the final dword of a packet's last buffer is accepted. stat_word bits 31:16 carry the tag from command B bits 31:16 of the packet's first buffer. The collision count in bits 6:3 reads 0, and bits 15:0 are all zero for a clean packet.
- R6: Command B bits 10:0 of the first buffer give the packet length. If it differs from the sum of the packet's buffer sizes, the status word has bit 15 (error) and bit 13 (length mismatch) set.
- R7: A first-segment buffer that arrives while a packet is still open produces a status word for the open packet, with its tag and with bits 15 and 12 set. The new buffer then starts a fresh packet with mac_sop.
- R8: A buffer without the first-segment flag that arrives while no packet is open is read completely, including its padding. None of its bytes are forwarded and it produces no status.
- R9: While mac_valid is high and mac_ready is low, mac_data, mac_sop and mac_eop hold their values.
- R10: During and just after reset, mac_valid and stat_valid are low, fifo_ready is high, and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_valid | input | 1 | FIFO holds a dword |
| fifo_data | input | 32 | Dword at the FIFO head |
| fifo_ready | output | 1 | Block consumes the head dword this cycle |
| mac_valid | output | 1 | A payload byte is offered |
| mac_data | output | 8 | Payload byte |
| mac_sop | output | 1 | First byte of a packet |
| mac_eop | output | 1 | Last byte of a packet |
| mac_ready | input | 1 | MAC takes the offered byte |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_word | output | 32 | Status: tag, error, mismatch and abort bits |

## Verification
The status pulse and the last bytes of the same packet overlap in time. The final dword of a buffer is loaded into the byte stage on the same edge that raises the status, so the end byte can be taken in the same cycle that stat_valid is seen, or in a later cycle. The bench holds mac_ready high and sends two buffers whose final dwords contain different numbers of payload bytes: one byte and two bytes. It records the cycle of the status strobe and the cycle of the end byte. It expects the two to coincide for the one-byte case and to be one cycle apart for the two-byte case. The same overlap lets a new command A be accepted while the previous packet is still draining, so the bench also checks that the next packet's start byte follows the end byte.

// File: rtl/txp_pkg.sv
`timescale 1ns/1ps
package txp_pkg;
  localparam int DW      = 32;
  localparam int BYTES   = DW / 8;
  localparam int IDX_W   = $clog2(BYTES);
  localparam int SIZE_W  = 11;
  localparam int OFF_W   = 5;
  localparam int TAG_W   = 16;
  localparam int POS_W   = 12;
  localparam int SUM_W   = 16;

  localparam int SZ_LSB    = 0;
  localparam int OFF_LSB   = 16;
  localparam int AL_LSB    = 24;
  localparam int FIRST_BIT = 13;
  localparam int LAST_BIT  = 12;
  localparam int TAG_LSB   = 16;
  localparam int PLEN_LSB  = 0;

  typedef enum logic [1:0] {S_CMDA, S_CMDB, S_DATA, S_PAD} parse_st_t;

  typedef struct packed {
    logic [DW-1:0]    data;
    logic [BYTES-1:0] keep;
    logic             sop;
    logic             eop;
  } lane_t;

  function automatic logic [5:0] align_bytes(input logic [1:0] code);
    case (code)
      2'd1:    align_bytes = 6'd16;
      2'd2:    align_bytes = 6'd32;
      default: align_bytes = 6'd4;
    endcase
  endfunction
endpackage

// File: rtl/txp_cmd_parse.sv
`timescale 1ns/1ps
module txp_cmd_parse
  import txp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  output lane_t            lane,
  output logic             lane_push,
  input  logic             lane_ready,
  output logic             pkt_done,
  output logic             pkt_abort,
  output logic [TAG_W-1:0] pkt_tag,
  output logic             pkt_mism
);
  parse_st_t           st;
  logic [OFF_W-1:0]    off_r;
  logic [POS_W-1:0]    end_r, pos_r, dw_left, pad_left;
  logic                first_r, last_r, drop_r, open_r, need_sop_r;
  logic [SUM_W-1:0]    sum_r;
  logic [SIZE_W-1:0]   plen_r;
  logic [TAG_W-1:0]    tag_r;

  logic [SIZE_W-1:0]   a_size;
  logic [OFF_W-1:0]    a_off;
  logic [1:0]          a_align;
  logic                a_first, a_last;
  logic [POS_W-1:0]    a_end, a_r4, a_al, a_ra, a_ndw, a_npd;
  logic                hs, buf_end;
  logic [BYTES-1:0]    keep_c, eop_c;
  logic [SIZE_W-1:0]   plen_now;

  always_comb begin
    a_size  = in_data[SZ_LSB +: SIZE_W];
    a_off   = in_data[OFF_LSB +: OFF_W];
    a_align = in_data[AL_LSB +: 2];
    a_first = in_data[FIRST_BIT];
    a_last  = in_data[LAST_BIT];
    a_end   = POS_W'(a_off) + POS_W'(a_size);
    a_r4    = (a_end + POS_W'(3)) & ~POS_W'(3);
    a_al    = POS_W'(align_bytes(a_align));
    a_ra    = (a_end + a_al - POS_W'(1)) & ~(a_al - POS_W'(1));
    a_ndw   = a_r4 >> 2;
    a_npd   = (a_ra - a_r4) >> 2;
  end

  assign in_ready = (st == S_DATA) ? lane_ready : 1'b1;
  assign hs       = in_valid && in_ready;

  generate
    for (genvar j = 0; j < BYTES; j++) begin : g_lane
      logic [POS_W-1:0] idx;
      assign idx       = pos_r + POS_W'(j);
      assign keep_c[j] = !drop_r && (idx >= POS_W'(off_r)) && (idx < end_r);
      assign eop_c[j]  = keep_c[j] && last_r && (idx == end_r - POS_W'(1));
    end
  endgenerate

  assign lane.data = in_data;
  assign lane.keep = keep_c;
  assign lane.sop  = need_sop_r && (|keep_c);
  assign lane.eop  = |eop_c;
  assign lane_push = hs && (st == S_DATA) && (|keep_c);

  always_comb begin
    case (st)
      S_CMDB:  buf_end = hs && (dw_left == '0) && (pad_left == '0);
      S_DATA:  buf_end = hs && (dw_left == POS_W'(1)) && (pad_left == '0);
      S_PAD:   buf_end = hs && (pad_left == POS_W'(1));
      default: buf_end = 1'b0;
    endcase
  end

  assign pkt_tag   = (st == S_CMDB && first_r) ? in_data[TAG_LSB +: TAG_W] : tag_r;
  assign plen_now  = (st == S_CMDB && first_r) ? in_data[PLEN_LSB +: SIZE_W] : plen_r;
  assign pkt_mism  = (sum_r != SUM_W'(plen_now));
  assign pkt_done  = buf_end && last_r && !drop_r;
  assign pkt_abort = hs && (st == S_CMDA) && a_first && open_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_CMDA;
      off_r      <= '0;
      end_r      <= '0;
      pos_r      <= '0;
      dw_left    <= '0;
      pad_left   <= '0;
      first_r    <= 1'b0;
      last_r     <= 1'b0;
      drop_r     <= 1'b0;
      open_r     <= 1'b0;
      need_sop_r <= 1'b0;
      sum_r      <= '0;
      plen_r     <= '0;
      tag_r      <= '0;
    end else if (hs) begin
      case (st)
        S_CMDA: begin
          off_r    <= a_off;
          end_r    <= a_end;
          pos_r    <= '0;
          dw_left  <= a_ndw;
          pad_left <= a_npd;
          first_r  <= a_first;
          last_r   <= a_last;
          if (a_first) begin
            open_r     <= 1'b1;
            need_sop_r <= 1'b1;
            sum_r      <= SUM_W'(a_size);
            drop_r     <= 1'b0;
          end else if (open_r) begin
            sum_r  <= sum_r + SUM_W'(a_size);
            drop_r <= 1'b0;
          end else begin
            drop_r <= 1'b1;
          end
          st <= S_CMDB;
        end
        S_CMDB: begin
          if (first_r) begin
            tag_r  <= in_data[TAG_LSB +: TAG_W];
            plen_r <= in_data[PLEN_LSB +: SIZE_W];
          end
          if (buf_end)              st <= S_CMDA;
          else if (dw_left != '0)   st <= S_DATA;
          else                      st <= S_PAD;
        end
        S_DATA: begin
          pos_r   <= pos_r + POS_W'(BYTES);
          dw_left <= dw_left - POS_W'(1);
          if (|keep_c) need_sop_r <= 1'b0;
          if (dw_left == POS_W'(1)) st <= (pad_left != '0) ? S_PAD : S_CMDA;
        end
        default: begin
          pad_left <= pad_left - POS_W'(1);
          if (pad_left == POS_W'(1)) st <= S_CMDA;
        end
      endcase
      if (pkt_done) open_r <= 1'b0;
    end
  end
endmodule

// File: rtl/txp_byte_ser.sv
`timescale 1ns/1ps
module txp_byte_ser
  import txp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lane_t      lane,
  input  logic       push,
  output logic       ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop,
  input  logic       out_ready
);
  logic [DW-1:0]    data_r;
  logic [BYTES-1:0] keep_r;
  logic             sop_r, eop_r, one_left;
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int j = BYTES - 1; j >= 0; j--)
      if (keep_r[j]) idx = IDX_W'(j);
  end

  assign one_left  = (keep_r != '0) && ((keep_r & (keep_r - BYTES'(1))) == '0);
  assign out_valid = (keep_r != '0);
  assign out_data  = data_r[idx*8 +: 8];
  assign out_sop   = sop_r && out_valid;
  assign out_eop   = eop_r && one_left;
  assign ready     = (keep_r == '0) || (out_ready && one_left);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_r <= '0;
      keep_r <= '0;
      sop_r  <= 1'b0;
      eop_r  <= 1'b0;
    end else if (push && ready) begin
      data_r <= lane.data;
      keep_r <= lane.keep;
      sop_r  <= lane.sop;
      eop_r  <= lane.eop;
    end else if (out_valid && out_ready) begin
      keep_r <= keep_r & (keep_r - BYTES'(1));
      sop_r  <= 1'b0;
    end
  end
endmodule

// File: rtl/txp_status.sv
`timescale 1ns/1ps
module txp_status
  import txp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             abort,
  input  logic [TAG_W-1:0] tag,
  input  logic             mism,
  output logic             stat_valid,
  output logic [DW-1:0]    stat_word
);
  logic err_m;
  assign err_m = done && mism;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid <= 1'b0;
      stat_word  <= '0;
    end else begin
      stat_valid <= done || abort;
      if (done || abort)
        stat_word <= {tag, (err_m || abort), 1'b0, err_m, abort, 12'd0};
    end
  end
endmodule

// File: rtl/tx_cmd_parser.sv
`timescale 1ns/1ps
module tx_cmd_parser
  import txp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_valid,
  input  logic [31:0]   fifo_data,
  output logic          fifo_ready,
  output logic          mac_valid,
  output logic [7:0]    mac_data,
  output logic          mac_sop,
  output logic          mac_eop,
  input  logic          mac_ready,
  output logic          stat_valid,
  output logic [31:0]   stat_word
);
  lane_t            lane;
  logic             lane_push, lane_ready;
  logic             pkt_done, pkt_abort, pkt_mism;
  logic [TAG_W-1:0] pkt_tag;

  txp_cmd_parse u_parse (
    .clk(clk), .rst(rst),
    .in_valid(fifo_valid), .in_data(fifo_data), .in_ready(fifo_ready),
    .lane(lane), .lane_push(lane_push), .lane_ready(lane_ready),
    .pkt_done(pkt_done), .pkt_abort(pkt_abort), .pkt_tag(pkt_tag), .pkt_mism(pkt_mism)
  );

  txp_byte_ser u_ser (
    .clk(clk), .rst(rst),
    .lane(lane), .push(lane_push), .ready(lane_ready),
    .out_valid(mac_valid), .out_data(mac_data), .out_sop(mac_sop), .out_eop(mac_eop),
    .out_ready(mac_ready)
  );

  txp_status u_stat (
    .clk(clk), .rst(rst),
    .done(pkt_done), .abort(pkt_abort), .tag(pkt_tag), .mism(pkt_mism),
    .stat_valid(stat_valid), .stat_word(stat_word)
  );
endmodule

// File: rtl/txp_checker.sv
`timescale 1ns/1ps
module txp_checker (
  input logic       clk,
  input logic       rst,
  input logic       mac_valid,
  input logic [7:0] mac_data,
  input logic       mac_sop,
  input logic       mac_eop,
  input logic       mac_ready,
  input logic       stat_valid
);
  assert_hold_when_stalled_R9: assert property (@(posedge clk) disable iff (rst)
    (mac_valid && !mac_ready) |=> (mac_valid && $stable(mac_data) && $stable(mac_sop) && $stable(mac_eop)));

  assert_markers_need_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (mac_sop || mac_eop) |-> mac_valid);

  assert_start_after_end_R4: assert property (@(posedge clk) disable iff (rst)
    (mac_valid && mac_ready && mac_eop) |=> (!mac_valid || mac_sop));

  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mac_valid && !stat_valid));
endmodule

bind tx_cmd_parser txp_checker u_chk (
  .clk(clk), .rst(rst), .mac_valid(mac_valid), .mac_data(mac_data),
  .mac_sop(mac_sop), .mac_eop(mac_eop), .mac_ready(mac_ready), .stat_valid(stat_valid)
);

// File: tb/sim_tx_cmd_parser.sv
`timescale 1ns/1ps
module sim_tx_cmd_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_valid = 1'b0;
  logic [31:0] fifo_data = '0;
  logic        fifo_ready;
  logic        mac_valid, mac_sop, mac_eop, mac_ready = 1'b1;
  logic [7:0]  mac_data;
  logic        stat_valid;
  logic [31:0] stat_word;

  int checks = 0, failures = 0, cyc = 0;
  bit stall_en = 1'b0;

  tx_cmd_parser u0 (
    .clk(clk), .rst(rst), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_ready(fifo_ready), .mac_valid(mac_valid), .mac_data(mac_data),
    .mac_sop(mac_sop), .mac_eop(mac_eop), .mac_ready(mac_ready),
    .stat_valid(stat_valid), .stat_word(stat_word)
  );

  always #2.5 clk = ~clk;

  // row fields: [4:0] offset, [15:5] size, [17:16] align, [18] first, [19] last, [30:20] length
  localparam int NROW = 11;
  localparam logic [31:0] ROWS [0:NROW-1] = '{
    {1'b0, 11'd60, 1'b1, 1'b1, 2'd0, 11'd60, 5'd2},
    {1'b0, 11'd13, 1'b1, 1'b1, 2'd1, 11'd13, 5'd7},
    {1'b0, 11'd14, 1'b0, 1'b1, 2'd2, 11'd5,  5'd0},
    {1'b0, 11'd14, 1'b1, 1'b0, 2'd0, 11'd9,  5'd3},
    {1'b0, 11'd12, 1'b1, 1'b1, 2'd0, 11'd10, 5'd1},
    {1'b0, 11'd16, 1'b0, 1'b1, 2'd0, 11'd8,  5'd0},
    {1'b0, 11'd4,  1'b1, 1'b1, 2'd1, 11'd4,  5'd0},
    {1'b0, 11'd4,  1'b1, 1'b0, 2'd0, 11'd4,  5'd0},
    {1'b0, 11'd1,  1'b1, 1'b1, 2'd2, 11'd1,  5'd31},
    {1'b0, 11'd3,  1'b1, 1'b1, 2'd3, 11'd3,  5'd0},
    {1'b0, 11'd2,  1'b1, 1'b1, 2'd0, 11'd2,  5'd0}
  };

  logic [9:0]  exp_b [0:1023];
  logic [9:0]  got_b [0:1023];
  logic [31:0] exp_s [0:63];
  logic [31:0] got_s [0:63];
  int exp_n = 0, got_n = 0, exp_sn = 0, got_sn = 0;
  int eop_cyc = 0, stat_cyc = 0;

  bit          m_open = 0, m_drop = 0, m_need_sop = 0;
  int          m_sum = 0;
  logic [15:0] m_tag = '0;
  logic [10:0] m_plen = '0;
  logic [7:0]  pat = 8'h10;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    mac_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (!rst && mac_valid && mac_ready) begin
      got_b[got_n] = {mac_sop, mac_eop, mac_data};
      got_n++;
      if (mac_eop) eop_cyc = cyc;
    end
    if (!rst && stat_valid) begin
      got_s[got_sn] = stat_word;
      got_sn++;
      stat_cyc = cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired: actual cycle %0d expected under 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_dw(input logic [31:0] w);
    @(negedge clk);
    fifo_valid = 1'b1;
    fifo_data  = w;
    #1;
    while (!fifo_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle_in();
    @(negedge clk);
    fifo_valid = 1'b0;
  endtask

  task automatic send_buf(input int off, input int size, input int al, input bit first,
                          input bit last, input int plen, input logic [15:0] tag);
    int endb, r4, alb, ra, nd, np;
    logic [31:0] w;
    if (first) begin
      if (m_open) begin
        exp_s[exp_sn] = {m_tag, 16'h9000};
        exp_sn++;
      end
      m_open = 1; m_drop = 0; m_need_sop = 1; m_sum = size;
    end else if (m_open) begin
      m_sum += size; m_drop = 0;
    end else m_drop = 1;
    send_dw(32'(size) | (32'(off) << 16) | (32'(al) << 24) | (32'(first) << 13) | (32'(last) << 12));
    if (first) begin m_tag = tag; m_plen = 11'(plen); end
    send_dw({tag, 5'd0, 11'(plen)});
    endb = off + size;
    r4   = (endb + 3) / 4 * 4;
    alb  = (al == 1) ? 16 : (al == 2) ? 32 : 4;
    ra   = (endb + alb - 1) / alb * alb;
    nd   = r4 / 4;
    np   = (ra - r4) / 4;
    for (int d = 0; d < nd; d++) begin
      for (int j = 0; j < 4; j++) begin
        int idx = d * 4 + j;
        w[j*8 +: 8] = pat;
        if (!m_drop && idx >= off && idx < endb) begin
          exp_b[exp_n] = {m_need_sop, (last && idx == endb - 1), pat};
          exp_n++;
          m_need_sop = 0;
        end
        pat++;
      end
      send_dw(w);
    end
    for (int p = 0; p < np; p++) send_dw(32'hFACE_0000 | 32'(p));
    if (last && !m_drop) begin
      exp_s[exp_sn] = {m_tag, (m_sum != int'(m_plen)) ? 16'hA000 : 16'h0000};
      exp_sn++;
      m_open = 0;
    end
  endtask

  task automatic compare(input string req);
    idle_in();
    repeat (300) @(negedge clk);
    chk(req, "byte count (R3 padding, R8 orphan)", 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(req, "payload byte R1 R2", 32'(got_b[i][7:0]), 32'(exp_b[i][7:0]));
      chk(req, "start/end flags R4", 32'(got_b[i][9:8]), 32'(exp_b[i][9:8]));
    end
    chk(req, "status count R5", 32'(got_sn), 32'(exp_sn));
    for (int i = 0; i < exp_sn && i < got_sn; i++)
      chk(req, "status word R5 R6 R7", got_s[i], exp_s[i]);
    exp_n = 0; got_n = 0; exp_sn = 0; got_sn = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R10", "mac_valid in reset", 32'(mac_valid), 32'd0);
    chk("R10", "fifo_ready in reset", 32'(fifo_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk); #2;
    chk("R10", "mac_valid after reset", 32'(mac_valid), 32'd0);
    chk("R10", "stat_valid after reset", 32'(stat_valid), 32'd0);

    // table walk: offsets, alignments, multi-buffer, mismatch (row 4), abort (rows 5-6), orphan (row 7)
    for (int i = 0; i < NROW; i++) begin
      logic [31:0] r;
      r = ROWS[i];
      send_buf(int'(r[4:0]), int'(r[15:5]), int'(r[17:16]), r[18], r[19], int'(r[30:20]), 16'hA000 + 16'(i));
    end
    compare("table R1 R2 R3 R4 R5 R6 R7 R8");

    // R9: backpressure on the byte side while multi-buffer packets flow
    stall_en = 1'b1;
    send_buf(7, 13, 1, 1, 1, 13, 16'hB001);
    send_buf(0, 5, 2, 1, 0, 14, 16'hB002);
    send_buf(3, 9, 0, 0, 1, 14, 16'hB002);
    compare("stall R9");
    stall_en = 1'b0;

    // R5: status strobe overlaps the tail bytes of its packet
    send_buf(31, 1, 2, 1, 1, 1, 16'hC001);
    idle_in();
    repeat (20) @(negedge clk);
    chk("R5", "status vs end byte cycle gap (1 byte tail)", 32'(eop_cyc - stat_cyc), 32'd0);
    send_buf(2, 60, 0, 1, 1, 60, 16'hC002);
    idle_in();
    repeat (20) @(negedge clk);
    chk("R5", "status vs end byte cycle gap (2 byte tail)", 32'(eop_cyc - stat_cyc), 32'd1);
    compare("overlap R5");

    // R10: reset while a packet is open closes it
    send_dw(32'(40) | (32'(1) << 13));
    send_dw({16'hD000, 5'd0, 11'd40});
    send_dw(32'h0102_0304);
    send_dw(32'h0506_0708);
    idle_in();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk("R10", "mac_valid after mid-packet reset", 32'(mac_valid), 32'd0);
    chk("R10", "stat_valid after mid-packet reset", 32'(stat_valid), 32'd0);
    got_n = 0; got_sn = 0; exp_n = 0; exp_sn = 0;
    m_open = 0;
    send_buf(0, 6, 0, 1, 1, 6, 16'hD001);
    compare("post-reset R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule